// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked on-chip request bus to an 8192-word by 8-bit asynchronous static RAM. The RAM has two chip selects, one active low and one active high, an active-low output enable and an active-low write enable. A requester offers one access at a time: an address, write data and a direction flag, under a valid/ready handshake. The controller turns each request into a pin-level cycle and returns a one-cycle done pulse. After a read, the captured byte comes back with that pulse.

Every phase length is derived from the RAM's nanosecond minimums. Each minimum is divided by a clock-period parameter and rounded up to whole cycles, with at least one cycle per phase. A read holds the output enable low for the longest of the access time, the read cycle time and the output-enable delay. A write first spends a setup phase with the RAM selected and write enable high. It then pulls write enable low for the longer of the pulse-width and data-setup minimums.

The shared data bus is split into an output, an output-enable and an input toward the pad ring. The controller drives the bus only during the write-enable low window. When a write follows a read, the controller adds one extra idle cycle so that the RAM's output drivers have turned off before the controller drives the bus.

Top module: `sram_bridge`

## Requirements
- R1: While reset is active and directly after it, memCe1N=1, memCe2=0, memOeN=1, memWeN=1, memDqOe=0, rspDone=0 and reqReady=1.
- R2: The RAM counts as selected only when memCe1N=0 and memCe2=1. The controller asserts both selects together for the whole of each access. It releases both (memCe1N=1, memCe2=0) when idle. memOeN or memWeN is low only while the RAM is selected.
- R3: A read keeps memWeN=1 and memOeN=0 for RD_CYC cycles, which is 2 at the default 8 ns clock. It samples memDqIn on the last of those cycles. rspDone rises on the third falling clock edge after the accepting rising edge, with the sampled byte on rspRdata.
- R4: A write spends one setup cycle selected with memWeN=1. It then holds memWeN=0 for WP_CYC cycles, which is 2 at defaults. rspDone rises on the fourth falling clock edge after the accepting edge.
- R5: memDqOe=1 only while memWeN=0 and memOeN=1. memDqOut stays stable while it is driven. The controller and the RAM never drive the bus at the same time.
- R6: A write accepted directly after a read gets one extra idle cycle before the setup phase. Its done pulse therefore comes one cycle later, on the fifth falling edge. A write after a write, and a read after any access, get no extra cycle.
- R7: A request is taken when reqValid and reqReady are both 1 at a rising edge. reqReady is 1 only in idle. It is 0 from the cycle after acceptance through the done cycle, and 1 again in the cycle after done.
- R8: rspDone lasts exactly one cycle per accepted request.
- R9: memAddr stays stable for as long as the RAM stays selected.
- R10: The bytes written at the lowest and highest addresses (0 and 8191), and data patterns 00, FF, A5, 5A and 3C, read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Word address |
| reqWdata | input | 8 | Write byte |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Byte captured by the last read |
| memAddr | output | 13 | RAM address pins |
| memCe1N | output | 1 | RAM select, active low |
| memCe2 | output | 1 | RAM select, active high |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDqOut | output | 8 | Data driven toward the RAM |
| memDqOe | output | 1 | Drive enable for the data pads |
| memDqIn | input | 8 | Data received from the RAM |

## Verification
Some rules are checked on every cycle by the assertions:
- the strobe encoding: write or output enable only while selected, and never both low together;
- the bus drive window;
- address and write-data stability while selected;
- the single-cycle done pulse and the deselected idle state.

Other behaviour only the bench scenarios can show, because it depends on how long phases last and how accesses follow each other:
- the exact cycle counts of the output-enable and write-enable phases;
- the extra turnaround cycle when a write follows a read;
- data integrity through a behavioural RAM model at both address extremes;
- the absence of bus contention against that model.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WSET, ST_WPUL, ST_RACC, ST_DONE
  } state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic sel;      // both chip selects active
    logic rdEn;     // output enable active
    logic wrEn;     // write enable active
    logic drive;    // drive the data pads
    logic load;     // latch request address / data
    logic capture;  // sample read data
  } strobe_t;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
#(
  parameter int CLK_NS   = 8,
  parameter int T_AA_NS  = 15,
  parameter int T_RC_NS  = 15,
  parameter int T_DOE_NS = 7,
  parameter int T_PWE_NS = 10,
  parameter int T_SD_NS  = 9,
  parameter int T_SA_NS  = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    rspDone,
  output strobe_t strb
);

  localparam int RD_CYC = maxOf(maxOf(nsToCyc(T_AA_NS, CLK_NS), nsToCyc(T_RC_NS, CLK_NS)),
                                nsToCyc(T_DOE_NS, CLK_NS));
  localparam int WP_CYC = maxOf(nsToCyc(T_PWE_NS, CLK_NS), nsToCyc(T_SD_NS, CLK_NS));
  localparam int WS_CYC = nsToCyc(T_SA_NS, CLK_NS);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), WS_CYC);
  localparam int CNT_W  = $clog2(MAX_CYC) + 1;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             lastRd;
  logic             accept;
  logic             cntZero;

  assign accept  = (state == ST_IDLE) && reqValid;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      lastRd <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          lastRd <= !reqWrite;
          if (!reqWrite) begin
            state <= ST_RACC;
            cnt   <= CNT_W'(RD_CYC - 1);
          end else if (lastRd) begin
            state <= ST_TURN;
          end else begin
            state <= ST_WSET;
            cnt   <= CNT_W'(WS_CYC - 1);
          end
        end
        ST_TURN: begin
          state <= ST_WSET;
          cnt   <= CNT_W'(WS_CYC - 1);
        end
        ST_WSET: if (cntZero) begin
          state <= ST_WPUL;
          cnt   <= CNT_W'(WP_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_WPUL, ST_RACC: if (cntZero) state <= ST_DONE;
                          else cnt <= cnt - 1'b1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspDone  = (state == ST_DONE);

  always_comb begin
    strb.sel     = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_RACC);
    strb.rdEn    = (state == ST_RACC);
    strb.wrEn    = (state == ST_WPUL);
    strb.drive   = (state == ST_WPUL);
    strb.load    = accept;
    strb.capture = (state == ST_RACC) && cntZero;
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strb.sel && !rspDone);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  capture_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rspDone);

endmodule

// File: rtl/sram_bridge_dpath.sv
module sram_bridge_dpath
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memCe1N  = !strb.sel;
  assign memCe2   = strb.sel;
  assign memOeN   = !strb.rdEn;
  assign memWeN   = !strb.wrEn;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.drive;
  assign rspRdata = rdataQ;

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && memOeN));

  // R2
  we_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2));

  // R2
  oe_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCe1N && memCe2));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr));

  // R5
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_AA_NS  = 15,
  parameter int T_RC_NS  = 15,
  parameter int T_DOE_NS = 7,
  parameter int T_PWE_NS = 10,
  parameter int T_SD_NS  = 9,
  parameter int T_SA_NS  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  sram_bridge_ctrl #(
    .CLK_NS(CLK_NS), .T_AA_NS(T_AA_NS), .T_RC_NS(T_RC_NS), .T_DOE_NS(T_DOE_NS),
    .T_PWE_NS(T_PWE_NS), .T_SD_NS(T_SD_NS), .T_SA_NS(T_SA_NS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspDone(rspDone), .strb(strb)
  );

  sram_bridge_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

endmodule

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspDone;
  logic [7:0]  rspRdata;
  logic [12:0] memAddr;
  logic        memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut, memDqIn;

  always #4 clk = ~clk;  // 125 MHz

  sram_bridge u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural RAM model
  logic [7:0]  mem [0:8191];
  logic        selM, modelDrv;
  int          weLen = 0, oeLen = 0, lastWe = 0, lastOe = 0;
  int          contention = 0, badStrobe = 0, addrMoved = 0;
  logic [12:0] selAddr;
  bit          wasSel = 0;

  assign selM     = !memCe1N && memCe2;
  assign modelDrv = selM && memWeN && !memOeN;
  assign memDqIn  = modelDrv ? mem[memAddr] : 8'hxx;

  always @(negedge clk) begin
    if (selM && !memWeN) begin
      weLen++;
      if (memDqOe) mem[memAddr] = memDqOut;
    end else if (weLen != 0) begin
      lastWe = weLen; weLen = 0;
    end
    if (modelDrv) oeLen++;
    else if (oeLen != 0) begin lastOe = oeLen; oeLen = 0; end
    if (memDqOe && modelDrv) contention++;
    if (!selM && (!memWeN || !memOeN)) badStrobe++;
    if (selM && wasSel && memAddr != selAddr) addrMoved++;
    if (selM && !wasSel) selAddr = memAddr;
    wasSel = selM;
  end

  // scoreboard
  typedef struct { bit rd; logic [12:0] a; logic [7:0] d; } item_t;
  item_t sbQ[$];
  logic [7:0] shadow [int];

  always @(negedge clk) begin
    if (rstN && rspDone) begin
      if (sbQ.size() == 0) chk("R8 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sbQ.pop_front();
        if (it.rd) chk("R10 read data", int'(rspRdata), int'(it.d));
      end
    end
  end

  task automatic doReq(input bit wr, input logic [12:0] a, input logic [7:0] d,
                       input int expLat, input string tag);
    item_t it;
    int lat;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[int'(a)] = d;
    it.rd = !wr; it.a = a; it.d = wr ? d : shadow[int'(a)];
    sbQ.push_back(it);
    @(negedge clk);
    reqValid = 0;
    chk("R7 ready low when busy", int'(reqReady), 0);
    lat = 1;
    while (!rspDone && lat < 50) begin @(negedge clk); lat++; end
    chk(tag, lat, expLat);
    @(negedge clk);
    chk("R8 done one cycle", int'(rspDone), 0);
    chk("R7 ready back after done", int'(reqReady), 1);
    chk("R2 idle deselect", int'({memCe1N, memCe2}), 2);
    if (wr) chk("R4 write enable low cycles", lastWe, 2);
    else    chk("R3 output enable low cycles", lastOe, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ce1 high", int'(memCe1N), 1);
    chk("R1 ce2 low", int'(memCe2), 0);
    chk("R1 oe high", int'(memOeN), 1);
    chk("R1 we high", int'(memWeN), 1);
    chk("R1 bus released", int'(memDqOe), 0);
    chk("R1 done low", int'(rspDone), 0);
    chk("R1 ready", int'(reqReady), 1);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle after reset", int'({memCe1N, memCe2, memOeN, memWeN}), 4'b1011);

    doReq(1, 13'd0,    8'hA5, 4, "R4 write latency");
    doReq(1, 13'd8191, 8'h5A, 4, "R6 write after write latency");
    doReq(0, 13'd0,    8'h00, 3, "R3 read latency");
    doReq(0, 13'd8191, 8'h00, 3, "R3 read after read latency");
    doReq(1, 13'd100,  8'hFF, 5, "R6 write after read latency");
    doReq(1, 13'd101,  8'h00, 4, "R6 no gap write after write");
    doReq(0, 13'd100,  8'h00, 3, "R6 read after write latency");
    doReq(0, 13'd101,  8'h00, 3, "R3 read latency");
    doReq(1, 13'd200,  8'h3C, 5, "R6 write after read latency");
    doReq(0, 13'd200,  8'h00, 3, "R10 read back");
    doReq(0, 13'd0,    8'h00, 3, "R10 low address retained");

    repeat (3) @(negedge clk);
    chk("R5 bus contention", contention, 0);
    chk("R2 strobe while deselected", badStrobe, 0);
    chk("R9 address moved while selected", addrMoved, 0);
    chk("R8 all responses seen", sbQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL R7 watchdog act=hung exp=complete");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule